// File: doc/BRIEF.md
# Blocking Cache Miss Buffer

This unit tracks the outstanding traffic of a blocking cache. It has two slots: one miss slot and one writeback slot. Each slot has its own blocked flag that goes back to the cache pipeline. Misses and eviction writebacks are loaded into these slots. Each loaded slot raises a request on the memory bus. A slot either retires at issue time, for traffic that expects no reply, or waits for a response. When the response arrives, the slot frees itself and forwards data to the waiting requester.

Cacheable misses become line fills. While a line fill is on the bus, the bus sees a dedicated fill command in place of the requester's command. The saved original command comes back out on `orig_cmd_o` when the fill completes. Some writes go to the writeback slot instead of the miss slot: writes that are uncacheable, writes made while write-allocate is off, and writes that expect no reply. A thread squash removes the requester from a pending miss. The miss itself still runs to completion, but nothing completes back to the requester.

Top module: `miss_buf`

## Requirements
- R1: After reset both blocked flags, the bus request, `fill_done_o` and `cpl_vld_o` are low.
- R2: The bus address is the block address: the request address with its low log2(BLK_BYTES) bits cleared (6 bits by default).
- R3: A miss write goes to the writeback slot if it is uncacheable, or if `wa_en_i` is low, or if it expects no response. The writeback slot then raises `blk_wb_o`, and `bus_sel_wb_o` is 1 while that slot requests. Every other miss loads the miss slot and raises `blk_miss_o`.
- R4: A cacheable request in the miss slot is a line fill. Its bus command is FILL_CMD (default 3'd6) in place of its own command.
- R5: An uncacheable request in the miss slot keeps its own command on the bus.
- R6: When a slot whose request expects no response is granted (`bus_req_o` and `bus_gnt_i` high at one edge), the slot frees at that edge. Its blocked flag is low in the next cycle.
- R7: When a slot that expects a response is granted, its request drops and it stays blocked until the response arrives.
- R8: A response for a line fill frees the miss slot. One cycle later it pulses `fill_done_o`, with `orig_cmd_o` equal to the requester's saved command and `cpl_vld_o` low.
- R9: A non-fill read response frees its slot. One cycle later it pulses `cpl_vld_o`, with the requester id on `cpl_rid_o`, the response data on `cpl_data_o`, and the saved command on `orig_cmd_o`.
- R10: A write response (`rsp_wb_i`=1) frees the writeback slot and completes to its requester with `cpl_data_o` equal to zero.
- R11: A squash whose thread matches the pending miss clears its target. The miss still runs to completion but produces no `cpl_vld_o`. A squash for another thread has no effect.
- R12: An eviction loads the writeback slot as a no-response buffer with command WB_CMD (default 3'd5). It takes precedence over a miss routed to the writeback slot in the same cycle.
- R13: When both slots are pending and no request is being held, the writeback slot is presented first. A presented request keeps its slot, address and command until granted.
- R14: A miss or eviction aimed at a slot that is already occupied is dropped. The occupant's address and command are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wa_en_i | input | 1 | Write-allocate enable |
| miss_vld_i | input | 1 | Miss request strobe |
| miss_addr_i | input | AW | Miss byte address |
| miss_cmd_i | input | CW | Requester command |
| miss_write_i | input | 1 | Miss is a write |
| miss_uncache_i | input | 1 | Miss is uncacheable |
| miss_noresp_i | input | 1 | Miss expects no response |
| miss_tid_i | input | TW | Requester thread |
| miss_rid_i | input | IW | Requester id |
| evict_vld_i | input | 1 | Eviction writeback strobe |
| evict_addr_i | input | AW | Eviction address |
| squash_vld_i | input | 1 | Thread squash strobe |
| squash_tid_i | input | TW | Thread to squash |
| blk_miss_o | output | 1 | Miss slot occupied |
| blk_wb_o | output | 1 | Writeback slot occupied |
| bus_req_o | output | 1 | Bus request |
| bus_sel_wb_o | output | 1 | Request comes from writeback slot |
| bus_addr_o | output | AW | Bus block address |
| bus_cmd_o | output | CW | Bus command |
| bus_gnt_i | input | 1 | Issue handshake |
| rsp_vld_i | input | 1 | Response strobe |
| rsp_wb_i | input | 1 | Response belongs to writeback slot |
| rsp_data_i | input | DW | Response data |
| fill_done_o | output | 1 | Line fill retired |
| cpl_vld_o | output | 1 | Completion to requester |
| cpl_rid_o | output | IW | Completed requester id |
| cpl_data_o | output | DW | Completion data |
| orig_cmd_o | output | CW | Restored requester command |

## Verification
The bench runs a seeded random series of misses. Each miss draws its write, uncacheable and no-response bits, the write-allocate setting, its address, thread and command at random, and is taken through issue and response. These misses tell apart the two slot routings, fill from non-fill command selection, freeing at issue from freeing at response, and read from write completion data. Directed cases cover the rest:
- a miss and an eviction loaded together, to show which slot is presented first;
- an eviction arriving behind an ungranted miss, to show the held request keeps its slot;
- matching and non-matching squashes;
- requests aimed at occupied slots;
- an eviction colliding with a miss that is routed to the writeback slot.

// File: rtl/mbuf_pkg.sv
package mbuf_pkg;
  localparam int NSLOT   = 2;
  localparam int SLOT_MS = 0;
  localparam int SLOT_WB = 1;
endpackage

// File: rtl/mbuf_slot.sv
module mbuf_slot #(
  parameter int AW = 32,
  parameter int CW = 3,
  parameter int TW = 2,
  parameter int IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [CW-1:0] a_cmd_i,
  input  logic [TW-1:0] a_tid_i,
  input  logic [IW-1:0] a_rid_i,
  input  logic          a_noresp_i,
  input  logic          a_fill_i,
  input  logic          a_write_i,
  input  logic          issue_i,
  input  logic          retire_i,
  input  logic          squash_i,
  input  logic [TW-1:0] squash_tid_i,
  output logic          valid_o,
  output logic          pend_o,
  output logic          noresp_o,
  output logic          fill_o,
  output logic          tgt_o,
  output logic          write_o,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cmd_o,
  output logic [IW-1:0] rid_o
);
  logic          valid_q, in_svc_q, noresp_q, fill_q, tgt_q, write_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cmd_q;
  logic [TW-1:0] tid_q;
  logic [IW-1:0] rid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      in_svc_q <= 1'b0;
      noresp_q <= 1'b0;
      fill_q   <= 1'b0;
      tgt_q    <= 1'b0;
      write_q  <= 1'b0;
      addr_q   <= '0;
      cmd_q    <= '0;
      tid_q    <= '0;
      rid_q    <= '0;
    end else if (alloc_i && !valid_q) begin
      valid_q  <= 1'b1;
      in_svc_q <= 1'b0;
      noresp_q <= a_noresp_i;
      fill_q   <= a_fill_i;
      tgt_q    <= !a_noresp_i;   // buffered traffic has no target
      write_q  <= a_write_i;
      addr_q   <= a_addr_i;
      cmd_q    <= a_cmd_i;
      tid_q    <= a_tid_i;
      rid_q    <= a_rid_i;
    end else begin
      if (issue_i && valid_q && !in_svc_q) begin
        if (noresp_q) valid_q  <= 1'b0;
        else          in_svc_q <= 1'b1;
      end
      if (retire_i && valid_q && in_svc_q) begin
        valid_q  <= 1'b0;
        in_svc_q <= 1'b0;
      end
      if (squash_i && valid_q && (tid_q == squash_tid_i)) tgt_q <= 1'b0;
    end
  end

  assign valid_o  = valid_q;
  assign pend_o   = valid_q && !in_svc_q;
  assign noresp_o = noresp_q;
  assign fill_o   = fill_q;
  assign tgt_o    = tgt_q;
  assign write_o  = write_q;
  assign addr_o   = addr_q;
  assign cmd_o    = cmd_q;
  assign rid_o    = rid_q;
endmodule

// File: rtl/mbuf_arb.sv
module mbuf_arb (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pend_i,   // [1] writeback, [0] miss
  input  logic       gnt_i,
  output logic       req_o,
  output logic       sel_wb_o,
  output logic       lock_o
);
  logic lock_q, lock_sel_q, pick_wb;

  assign pick_wb  = pend_i[1];
  assign req_o    = |pend_i;
  assign sel_wb_o = lock_q ? lock_sel_q : pick_wb;
  assign lock_o   = lock_q;

  // keep a presented request stable until its handshake
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q     <= 1'b0;
      lock_sel_q <= 1'b0;
    end else begin
      lock_q     <= req_o && !gnt_i;
      lock_sel_q <= sel_wb_o;
    end
  end
endmodule

// File: rtl/miss_buf.sv
module miss_buf #(
  parameter int            AW        = 32,
  parameter int            BLK_BYTES = 64,
  parameter int            CW        = 3,
  parameter int            TW        = 2,
  parameter int            IW        = 4,
  parameter int            DW        = 32,
  parameter logic [CW-1:0] FILL_CMD  = 3'd6,
  parameter logic [CW-1:0] WB_CMD    = 3'd5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wa_en_i,
  input  logic          miss_vld_i,
  input  logic [AW-1:0] miss_addr_i,
  input  logic [CW-1:0] miss_cmd_i,
  input  logic          miss_write_i,
  input  logic          miss_uncache_i,
  input  logic          miss_noresp_i,
  input  logic [TW-1:0] miss_tid_i,
  input  logic [IW-1:0] miss_rid_i,
  input  logic          evict_vld_i,
  input  logic [AW-1:0] evict_addr_i,
  input  logic          squash_vld_i,
  input  logic [TW-1:0] squash_tid_i,
  output logic          blk_miss_o,
  output logic          blk_wb_o,
  output logic          bus_req_o,
  output logic          bus_sel_wb_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [CW-1:0] bus_cmd_o,
  input  logic          bus_gnt_i,
  input  logic          rsp_vld_i,
  input  logic          rsp_wb_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic          fill_done_o,
  output logic          cpl_vld_o,
  output logic [IW-1:0] cpl_rid_o,
  output logic [DW-1:0] cpl_data_o,
  output logic [CW-1:0] orig_cmd_o
);
  import mbuf_pkg::*;

  localparam int            OFF_W    = $clog2(BLK_BYTES);
  localparam logic [AW-1:0] OFF_MASK = AW'((64'd1 << OFF_W) - 64'd1);

  logic          alloc   [NSLOT];
  logic [AW-1:0] a_addr  [NSLOT];
  logic [CW-1:0] a_cmd   [NSLOT];
  logic [IW-1:0] a_rid   [NSLOT];
  logic          a_noresp[NSLOT];
  logic          a_fill  [NSLOT];
  logic          a_write [NSLOT];
  logic          issue   [NSLOT];
  logic          retire  [NSLOT];
  logic          sq      [NSLOT];

  logic [NSLOT-1:0] valid, pend, noresp, fill, tgt, write;
  logic [AW-1:0] s_addr[NSLOT];
  logic [CW-1:0] s_cmd [NSLOT];
  logic [IW-1:0] s_rid [NSLOT];

  logic wb_route, arb_lock;
  int unsigned bsel, rsel;

  assign wb_route = miss_vld_i && miss_write_i &&
                    (miss_uncache_i || !wa_en_i || miss_noresp_i);

  always_comb begin
    // miss slot
    alloc[SLOT_MS]    = miss_vld_i && !wb_route;
    a_addr[SLOT_MS]   = miss_addr_i & ~OFF_MASK;
    a_cmd[SLOT_MS]    = miss_cmd_i;
    a_rid[SLOT_MS]    = miss_rid_i;
    a_noresp[SLOT_MS] = miss_noresp_i;
    a_fill[SLOT_MS]   = !miss_uncache_i;
    a_write[SLOT_MS]  = miss_write_i;
    // writeback slot: eviction wins over a routed write
    alloc[SLOT_WB]    = evict_vld_i || wb_route;
    a_addr[SLOT_WB]   = (evict_vld_i ? evict_addr_i : miss_addr_i) & ~OFF_MASK;
    a_cmd[SLOT_WB]    = evict_vld_i ? WB_CMD : miss_cmd_i;
    a_rid[SLOT_WB]    = evict_vld_i ? '0 : miss_rid_i;
    a_noresp[SLOT_WB] = evict_vld_i || miss_noresp_i;
    a_fill[SLOT_WB]   = 1'b0;
    a_write[SLOT_WB]  = 1'b1;
  end

  mbuf_arb u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  ({pend[SLOT_WB], pend[SLOT_MS]}),
    .gnt_i   (bus_gnt_i),
    .req_o   (bus_req_o),
    .sel_wb_o(bus_sel_wb_o),
    .lock_o  (arb_lock)
  );

  assign bsel = bus_sel_wb_o ? SLOT_WB : SLOT_MS;
  assign rsel = rsp_wb_i ? SLOT_WB : SLOT_MS;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign issue[i]  = bus_gnt_i && bus_req_o && (bsel == i);
    assign retire[i] = rsp_vld_i && (rsel == i);
    assign sq[i]     = (i == SLOT_MS) ? squash_vld_i : 1'b0;

    mbuf_slot #(.AW(AW), .CW(CW), .TW(TW), .IW(IW)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc[i]),
      .a_addr_i    (a_addr[i]),
      .a_cmd_i     (a_cmd[i]),
      .a_tid_i     (miss_tid_i),
      .a_rid_i     (a_rid[i]),
      .a_noresp_i  (a_noresp[i]),
      .a_fill_i    (a_fill[i]),
      .a_write_i   (a_write[i]),
      .issue_i     (issue[i]),
      .retire_i    (retire[i]),
      .squash_i    (sq[i]),
      .squash_tid_i(squash_tid_i),
      .valid_o     (valid[i]),
      .pend_o      (pend[i]),
      .noresp_o    (noresp[i]),
      .fill_o      (fill[i]),
      .tgt_o       (tgt[i]),
      .write_o     (write[i]),
      .addr_o      (s_addr[i]),
      .cmd_o       (s_cmd[i]),
      .rid_o       (s_rid[i])
    );
  end

  assign blk_miss_o = valid[SLOT_MS];
  assign blk_wb_o   = valid[SLOT_WB];
  assign bus_addr_o = s_addr[bsel];
  assign bus_cmd_o  = fill[bsel] ? FILL_CMD : s_cmd[bsel];

  logic rsp_ok;
  assign rsp_ok = rsp_vld_i && valid[rsel] && !pend[rsel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_done_o <= 1'b0;
      cpl_vld_o   <= 1'b0;
      cpl_rid_o   <= '0;
      cpl_data_o  <= '0;
      orig_cmd_o  <= '0;
    end else begin
      fill_done_o <= rsp_ok && fill[rsel];
      cpl_vld_o   <= rsp_ok && !fill[rsel] && tgt[rsel];
      if (rsp_ok) begin
        cpl_rid_o  <= s_rid[rsel];
        cpl_data_o <= write[rsel] ? '0 : rsp_data_i;
        orig_cmd_o <= s_cmd[rsel];   // restored requester command
      end
    end
  end
endmodule

// File: rtl/miss_buf_chk.sv
module miss_buf_chk #(
  parameter int            AW       = 32,
  parameter int            CW       = 3,
  parameter int            OFF_W    = 6,
  parameter logic [CW-1:0] FILL_CMD = 3'd6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    pend,
  input logic [1:0]    fill,
  input logic [1:0]    noresp,
  input logic          lock,
  input logic          bus_req_o,
  input logic          bus_sel_wb_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [CW-1:0] bus_cmd_o,
  input logic          bus_gnt_i,
  input logic          blk_wb_o,
  input logic          fill_done_o,
  input logic          cpl_vld_o,
  input logic          rsp_vld_i
);
  assert_wb_first_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend[1] && pend[0] && !lock) |-> bus_sel_wb_o);

  assert_req_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_sel_wb_o) &&
                                   $stable(bus_addr_o) && $stable(bus_cmd_o)));

  assert_fill_cmd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_sel_wb_o && fill[0]) |-> (bus_cmd_o == FILL_CMD));

  assert_blk_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_addr_o[OFF_W-1:0] == '0));

  assert_done_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_done_o && cpl_vld_o));

  assert_cpl_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_vld_o || fill_done_o) |-> $past(rsp_vld_i));

  assert_wb_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blk_wb_o) |-> bus_req_o);

  assert_nr_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_sel_wb_o && bus_gnt_i && noresp[1]) |=> !blk_wb_o);
endmodule

bind miss_buf miss_buf_chk #(
  .AW(AW), .CW(CW), .OFF_W(OFF_W), .FILL_CMD(FILL_CMD)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pend        (pend),
  .fill        (fill),
  .noresp      (noresp),
  .lock        (arb_lock),
  .bus_req_o   (bus_req_o),
  .bus_sel_wb_o(bus_sel_wb_o),
  .bus_addr_o  (bus_addr_o),
  .bus_cmd_o   (bus_cmd_o),
  .bus_gnt_i   (bus_gnt_i),
  .blk_wb_o    (blk_wb_o),
  .fill_done_o (fill_done_o),
  .cpl_vld_o   (cpl_vld_o),
  .rsp_vld_i   (rsp_vld_i)
);

// File: tb/miss_buf_test.sv
module miss_buf_test;
  localparam int AW = 32, CW = 3, TW = 2, IW = 4, DW = 32;
  localparam logic [CW-1:0] FILL = 3'd6, WBC = 3'd5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wa_en_i = 1'b1, miss_vld_i = 1'b0, miss_write_i = 1'b0;
  logic miss_uncache_i = 1'b0, miss_noresp_i = 1'b0;
  logic [AW-1:0] miss_addr_i = '0, evict_addr_i = '0;
  logic [CW-1:0] miss_cmd_i = '0;
  logic [TW-1:0] miss_tid_i = '0, squash_tid_i = '0;
  logic [IW-1:0] miss_rid_i = '0;
  logic evict_vld_i = 1'b0, squash_vld_i = 1'b0;
  logic bus_gnt_i = 1'b0, rsp_vld_i = 1'b0, rsp_wb_i = 1'b0;
  logic [DW-1:0] rsp_data_i = '0;
  logic blk_miss_o, blk_wb_o, bus_req_o, bus_sel_wb_o, fill_done_o, cpl_vld_o;
  logic [AW-1:0] bus_addr_o;
  logic [CW-1:0] bus_cmd_o, orig_cmd_o;
  logic [IW-1:0] cpl_rid_o;
  logic [DW-1:0] cpl_data_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  miss_buf uut (.*);

  function automatic logic [AW-1:0] exp_blk(logic [AW-1:0] a);
    return a & ~32'h3f;
  endfunction

  function automatic bit exp_wb(bit w, bit u, bit wa, bit nr);
    return w && (u || !wa || nr);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_miss(bit w, bit u, bit nr, logic [CW-1:0] c,
                         logic [AW-1:0] a, logic [TW-1:0] t, logic [IW-1:0] r);
    miss_vld_i = 1; miss_write_i = w; miss_uncache_i = u; miss_noresp_i = nr;
    miss_cmd_i = c; miss_addr_i = a; miss_tid_i = t; miss_rid_i = r;
    step();
    miss_vld_i = 0;
  endtask

  task automatic do_gnt();
    bus_gnt_i = 1; step(); bus_gnt_i = 0;
  endtask

  task automatic do_rsp(bit wb, logic [DW-1:0] d);
    rsp_vld_i = 1; rsp_wb_i = wb; rsp_data_i = d; step(); rsp_vld_i = 0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #5;
    chk("R1 blk_miss", blk_miss_o, 0);
    chk("R1 blk_wb", blk_wb_o, 0);
    chk("R1 bus_req", bus_req_o, 0);
    chk("R1 cpl", {fill_done_o, cpl_vld_o}, 0);
    rst_ni = 1;
    step();

    // random main loop
    for (int n = 0; n < 60; n++) begin
      bit w = 1'($urandom), u = 1'($urandom), nr = 1'($urandom), wa = 1'($urandom);
      logic [AW-1:0] a = $urandom;
      logic [CW-1:0] c = 3'($urandom % 5);
      logic [IW-1:0] r = 4'($urandom);
      logic [DW-1:0] d = $urandom;
      bit route;
      wa_en_i = wa;
      route = exp_wb(w, u, wa, nr);
      do_miss(w, u, nr, c, a, 2'($urandom), r);
      chk("R3 blk_wb", blk_wb_o, route);
      chk("R3 blk_miss", blk_miss_o, !route);
      chk("R3 sel_wb", bus_sel_wb_o, route);
      chk("R2 addr", bus_addr_o, exp_blk(a));
      chk("R4 R5 cmd", bus_cmd_o, (!route && !u) ? FILL : c);
      do_gnt();
      if (nr) begin
        chk("R6 freed", {blk_wb_o, blk_miss_o}, 0);
      end else begin
        chk("R7 held", route ? blk_wb_o : blk_miss_o, 1);
        chk("R7 req drop", bus_req_o, 0);
        do_rsp(route, d);
        if (!route && !u) begin
          chk("R8 fill_done", {fill_done_o, cpl_vld_o}, 2'b10);
          chk("R8 orig cmd", orig_cmd_o, c);
        end else begin
          chk("R9 R10 cpl", {fill_done_o, cpl_vld_o}, 2'b01);
          chk("R9 rid", cpl_rid_o, r);
          chk("R9 R10 data", cpl_data_o, w ? 0 : d);
          chk("R9 orig cmd", orig_cmd_o, c);
        end
        chk("R8 R9 R10 freed", {blk_wb_o, blk_miss_o}, 0);
      end
      step();
    end
    wa_en_i = 1;

    // R12 eviction and R13 priority
    miss_vld_i = 1; miss_write_i = 0; miss_uncache_i = 0; miss_noresp_i = 0;
    miss_cmd_i = 3'd1; miss_addr_i = 32'h1000_0044; miss_rid_i = 4'd3;
    evict_vld_i = 1; evict_addr_i = 32'h2000_00ff;
    step();
    miss_vld_i = 0; evict_vld_i = 0;
    chk("R13 wb first", bus_sel_wb_o, 1);
    chk("R12 wb cmd", bus_cmd_o, WBC);
    chk("R12 wb addr", bus_addr_o, 32'h2000_00c0);
    step();
    chk("R13 held sel", bus_sel_wb_o, 1);
    do_gnt();
    chk("R12 buffer freed", blk_wb_o, 0);
    chk("R13 miss next", {bus_req_o, bus_sel_wb_o}, 2'b10);
    // R14 busy miss slot
    do_miss(0, 1, 0, 3'd2, 32'h3000_0000, 0, 4'd9);
    chk("R14 addr kept", bus_addr_o, 32'h1000_0040);
    chk("R14 cmd kept", bus_cmd_o, FILL);
    // R13 held miss request not overtaken by a new eviction
    evict_vld_i = 1; evict_addr_i = 32'h4000_0000; step(); evict_vld_i = 0;
    chk("R13 hold miss", bus_sel_wb_o, 0);
    chk("R13 hold addr", bus_addr_o, 32'h1000_0040);
    do_gnt();
    chk("R13 wb after", bus_sel_wb_o, 1);
    // R14 busy writeback slot
    evict_vld_i = 1; evict_addr_i = 32'h5000_0000; step(); evict_vld_i = 0;
    chk("R14 wb kept", bus_addr_o, 32'h4000_0000);
    do_gnt();
    do_rsp(0, 32'hdead_beef);
    chk("R8 fill", {fill_done_o, cpl_vld_o}, 2'b10);
    chk("R8 orig", orig_cmd_o, 3'd1);

    // R12 eviction beats routed write in same cycle
    miss_vld_i = 1; miss_write_i = 1; miss_uncache_i = 1; miss_noresp_i = 0;
    miss_cmd_i = 3'd2; miss_addr_i = 32'h6000_0000;
    evict_vld_i = 1; evict_addr_i = 32'h7000_0000;
    step();
    miss_vld_i = 0; evict_vld_i = 0;
    chk("R12 evict wins", bus_addr_o, 32'h7000_0000);
    chk("R12 miss slot free", blk_miss_o, 0);
    do_gnt();

    // R11 squash matching thread
    do_miss(0, 1, 0, 3'd1, 32'h0000_0100, 2'd2, 4'd7);
    squash_vld_i = 1; squash_tid_i = 2'd2; step(); squash_vld_i = 0;
    chk("R11 still blocked", blk_miss_o, 1);
    do_gnt();
    do_rsp(0, 32'h1234);
    chk("R11 no cpl", {fill_done_o, cpl_vld_o}, 0);
    chk("R11 freed", blk_miss_o, 0);
    // R11 squash other thread
    do_miss(0, 1, 0, 3'd1, 32'h0000_0200, 2'd1, 4'd5);
    squash_vld_i = 1; squash_tid_i = 2'd3; step(); squash_vld_i = 0;
    do_gnt();
    do_rsp(0, 32'h5678);
    chk("R11 cpl kept", cpl_vld_o, 1);
    chk("R11 data", cpl_data_o, 32'h5678);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule